// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block holds the results of speculatively executed instructions in a circular queue and retires them strictly in the order they were issued. The issue stage asks for an entry along with the instruction kind and destination register. The entry is granted only when a reservation station is also free, and the entry number returned becomes the rename tag. Completing functional units return results over a broadcast result bus, addressed by entry number. Each result carries a value, an auxiliary word (a store address or a branch's correct successor PC) and a mispredict flag.

A per-register status table records which entry will produce each architectural register. The issue stage reads source operands through lookup ports. Each lookup says whether the register is waiting on an entry and, if it is, gives the entry number. When that entry already holds its result, the lookup also returns the value.

At the head of the queue, one entry is retired per cycle, and only once its result is present. An arithmetic entry writes its register. A store entry issues a memory write. A mispredicted branch discards every entry, clears the status table and redirects fetch.

Top module: `inorder_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` follows `rs_free`, `alloc_tag` is 0, `rf_we`, `st_valid` and `flush` are low, and no register reports pending.
- R2: An entry is taken only in a cycle with `alloc_valid`, `rs_free`, a non-full buffer and no flush. Entry numbers are handed out in ascending order and wrap from DEPTH-1 to 0. `alloc_tag` always shows the next number.
- R3: At most DEPTH entries are held. When the buffer is full, `alloc_ready` is low and a request is dropped without touching the status table.
- R4: A result for an entry that is not occupied is ignored. A later allocation of that entry must still wait for its own result.
- R5: Retirement happens only at the head, at most once per cycle, in allocation order, and only once the head's result has arrived. A finished younger entry cannot pass an unfinished head.
- R6: Kind code 2'b00 (arithmetic) retires with `rf_we` high, `rf_waddr` equal to its destination and `rf_wdata` equal to its result.
- R7: Kind code 2'b01 (store) retires with `st_valid` high, `st_addr` equal to the auxiliary word and `st_data` equal to the result. It does not write the register file and it does not rename any register.
- R8: Kind code 2'b10 (branch) with its mispredict flag set retires with `flush` high and `flush_pc` equal to the auxiliary word. Allocation is refused in that cycle, and the next cycle shows an empty buffer, tag 0, and no pending register. A branch without the flag retires with no output. The flag has no effect on other kinds.
- R9: A lookup of a register renamed by an arithmetic entry reports pending, with the newest producer's entry number. Once that entry holds its result, it also reports ready with the value.
- R10: When an arithmetic entry retires, its register's pending mark is cleared only if the status table still names that entry. A newer producer keeps the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rs_free | input | 1 | A reservation station is available for the instruction at issue |
| alloc_valid | input | 1 | Issue stage requests an entry |
| alloc_kind | input | 2 | 00 arithmetic, 01 store, 10 branch |
| alloc_dest | input | RW | Destination register (arithmetic only) |
| alloc_ready | output | 1 | Request would be accepted this cycle |
| alloc_tag | output | TW | Entry number given to an accepted request |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | TW | Entry the result belongs to |
| wb_value | input | DW | Result value or store data |
| wb_aux | input | AUXW | Store address or branch correct successor PC |
| wb_mispred | input | 1 | Branch was mispredicted |
| src_reg | input | NSRC*RW | Registers looked up, one field per port |
| src_busy | output | NSRC | Register awaits an in-flight producer |
| src_ready | output | NSRC | That producer's result is already held |
| src_tag | output | NSRC*TW | Producer entry number per port |
| src_value | output | NSRC*DW | Held result per port (zero when not ready) |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | RW | Register written |
| rf_wdata | output | DW | Value written |
| st_valid | output | 1 | Memory store request at retirement |
| st_addr | output | AUXW | Store address |
| st_data | output | DW | Store data |
| flush | output | 1 | Mispredicted branch retired; discard all work |
| flush_pc | output | AUXW | Fetch restart address |

## Verification
The bench uses a four-entry, eight-register configuration. A full fill with results returned out of order shows that retirement waits for the head and keeps program order across the wrap. Two back-to-back writers of the same register separate a correct conditional clear of the pending mark from an unconditional one. A sweep over every kind and both mispredict values checks which single retirement action each combination triggers. A flush with a finished younger entry behind the branch shows that nothing after the branch leaks out.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: kind codes are fixed because the issue stage encodes them.
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10,
        KIND_RSVD   = 2'b11
    } rob_kind_t;

    typedef enum logic {
        SLOT_WAITING = 1'b0,
        SLOT_RESULT  = 1'b1
    } rob_state_t;

endpackage

// File: rtl/rob_slots.sv
// Entry storage and head/tail/count pointers of the circular buffer.
// Assumes: DEPTH is a power of two, so a TW-bit tag addresses every entry.
// Results for unoccupied entries are dropped. Flush empties everything.
module rob_slots
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int RW    = 4,
    parameter int DW    = 32,
    parameter int AUXW  = 32,
    parameter int TW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_fire,
    input  rob_kind_t       alloc_kind,
    input  logic [RW-1:0]   alloc_dest,
    input  logic            wb_valid,
    input  logic [TW-1:0]   wb_tag,
    input  logic [DW-1:0]   wb_value,
    input  logic [AUXW-1:0] wb_aux,
    input  logic            wb_mispred,
    input  logic            retire_fire,
    input  logic            flush,
    output logic [TW-1:0]   head,
    output logic [TW-1:0]   tail,
    output logic            full,
    output logic            head_busy,
    output logic            head_done,
    output rob_kind_t       head_kind,
    output logic [RW-1:0]   head_dest,
    output logic [DW-1:0]   head_value,
    output logic [AUXW-1:0] head_aux,
    output logic            head_misp,
    output logic [DEPTH-1:0] done_vec,
    output logic [DW-1:0]   val_arr [DEPTH]
);

    logic [TW-1:0]   head_q, tail_q;
    logic [CW-1:0]   count_q;
    logic [DEPTH-1:0] busy_vec;
    logic [DEPTH-1:0] misp_vec;
    rob_kind_t       kind_arr [DEPTH];
    logic [RW-1:0]   dest_arr [DEPTH];
    logic [AUXW-1:0] aux_arr  [DEPTH];

    function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
        return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-entry state: allocate, capture result, retire.
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic            busy_r;
        rob_state_t      state_r;
        rob_kind_t       kind_r;
        logic [RW-1:0]   dest_r;
        logic [DW-1:0]   val_r;
        logic [AUXW-1:0] aux_r;
        logic            misp_r;
        logic            alloc_here, wb_here, retire_here;

        assign alloc_here  = alloc_fire && (tail_q == TW'(e));
        assign wb_here     = wb_valid && (wb_tag == TW'(e)) && busy_r;
        assign retire_here = retire_fire && (head_q == TW'(e));

        // Entry register update, reset first, flush next.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_r  <= 1'b0;
                state_r <= SLOT_WAITING;
                kind_r  <= KIND_ALU;
                dest_r  <= '0;
                val_r   <= '0;
                aux_r   <= '0;
                misp_r  <= 1'b0;
            end else if (flush) begin
                busy_r  <= 1'b0;
                state_r <= SLOT_WAITING;
            end else if (alloc_here) begin
                busy_r  <= 1'b1;
                state_r <= SLOT_WAITING;
                kind_r  <= alloc_kind;
                dest_r  <= alloc_dest;
                misp_r  <= 1'b0;
            end else begin
                if (wb_here) begin
                    state_r <= SLOT_RESULT;
                    val_r   <= wb_value;
                    aux_r   <= wb_aux;
                    misp_r  <= wb_mispred;
                end
                if (retire_here) begin
                    busy_r  <= 1'b0;
                    state_r <= SLOT_WAITING;
                end
            end
        end

        assign busy_vec[e] = busy_r;
        assign done_vec[e] = busy_r && (state_r == SLOT_RESULT);
        assign misp_vec[e] = misp_r;
        assign kind_arr[e] = kind_r;
        assign dest_arr[e] = dest_r;
        assign val_arr[e]  = val_r;
        assign aux_arr[e]  = aux_r;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_fire)  tail_q <= bump(tail_q);
            if (retire_fire) head_q <= bump(head_q);
            case ({alloc_fire, retire_fire})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign head       = head_q;
    assign tail       = tail_q;
    assign full       = (count_q == CW'(DEPTH));
    assign head_busy  = busy_vec[head_q];
    assign head_done  = done_vec[head_q];
    assign head_kind  = kind_arr[head_q];
    assign head_dest  = dest_arr[head_q];
    assign head_value = val_arr[head_q];
    assign head_aux   = aux_arr[head_q];
    assign head_misp  = misp_vec[head_q];

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (busy_vec == '0));

    assert_stray_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !busy_vec[wb_tag] && !flush) |=> !done_vec[$past(wb_tag)]);

    assert_single_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_fire && !alloc_fire && !flush) |=> (count_q == $past(count_q) - CW'(1)));

endmodule

// File: rtl/rob_rename_map.sv
// Register status table: newest producing entry and a pending bit per register.
// Assumes: NREG == 2**RW. A rename set wins over a same-cycle retire clear.
module rob_rename_map #(
    parameter int NREG = 16,
    parameter int NSRC = 2,
    parameter int RW   = $clog2(NREG),
    parameter int TW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              set_fire,
    input  logic [RW-1:0]     set_reg,
    input  logic [TW-1:0]     set_tag,
    input  logic              clr_fire,
    input  logic [RW-1:0]     clr_reg,
    input  logic [TW-1:0]     clr_tag,
    input  logic [NSRC*RW-1:0] src_reg,
    output logic [NSRC-1:0]   src_busy,
    output logic [NSRC*TW-1:0] src_tag
);

    logic [NREG-1:0] pend_vec;
    logic [TW-1:0]   tag_arr [NREG];

    // One status record per architectural register.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic          pend_r;
        logic [TW-1:0] tag_r;

        // Rename on allocation; conditional clear on retirement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r <= 1'b0;
                tag_r  <= '0;
            end else if (flush) begin
                pend_r <= 1'b0;
            end else if (set_fire && (set_reg == RW'(r))) begin
                pend_r <= 1'b1;
                tag_r  <= set_tag;
            end else if (clr_fire && (clr_reg == RW'(r)) && (tag_r == clr_tag)) begin
                pend_r <= 1'b0;
            end
        end

        assign pend_vec[r] = pend_r;
        assign tag_arr[r]  = tag_r;
    end

    // Lookup ports.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [RW-1:0] idx;
        assign idx                    = src_reg[s*RW +: RW];
        assign src_busy[s]            = pend_vec[idx];
        assign src_tag[s*TW +: TW]    = tag_arr[idx];
    end

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pend_vec == '0));

    assert_keep_newer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fire && !flush && !set_fire && pend_vec[clr_reg] && (tag_arr[clr_reg] != clr_tag))
        |=> pend_vec[$past(clr_reg)]);

endmodule

// File: rtl/rob_retire.sv
// Head decode: chooses the single retirement action for the head entry.
// Assumes: head fields are registered; outputs are combinational from them.
// Kind code 11 retires silently.
module rob_retire
    import rob_pkg::*;
#(
    parameter int RW   = 4,
    parameter int DW   = 32,
    parameter int AUXW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_busy,
    input  logic            head_done,
    input  rob_kind_t       head_kind,
    input  logic [RW-1:0]   head_dest,
    input  logic [DW-1:0]   head_value,
    input  logic [AUXW-1:0] head_aux,
    input  logic            head_misp,
    output logic            retire_fire,
    output logic            rf_we,
    output logic [RW-1:0]   rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            st_valid,
    output logic [AUXW-1:0] st_addr,
    output logic [DW-1:0]   st_data,
    output logic            flush,
    output logic [AUXW-1:0] flush_pc
);

    // Action select for the head entry.
    always_comb begin
        retire_fire = head_busy && head_done;
        rf_we       = 1'b0;
        st_valid    = 1'b0;
        flush       = 1'b0;
        unique case (head_kind)
            KIND_ALU:    rf_we    = retire_fire;
            KIND_STORE:  st_valid = retire_fire;
            KIND_BRANCH: flush    = retire_fire && head_misp;
            default:     ;
        endcase
    end

    assign rf_waddr = head_dest;
    assign rf_wdata = head_value;
    assign st_addr  = head_aux;
    assign st_data  = head_value;
    assign flush_pc = head_aux;

    assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_valid, flush}));

    assert_needs_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_valid || flush) |-> (head_busy && head_done));

endmodule

// File: rtl/inorder_rob.sv
// Reorder buffer top: allocation gate, entry store, register status
// table, operand lookup and head retirement.
// Assumes: DEPTH and NREG are powers of two. Lookups show state as of the
// start of the cycle, so a same-cycle result or rename is not yet visible.
module inorder_rob
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int AUXW  = 32,
    parameter int NSRC  = 2,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rs_free,
    input  logic               alloc_valid,
    input  logic [1:0]         alloc_kind,
    input  logic [RW-1:0]      alloc_dest,
    output logic               alloc_ready,
    output logic [TW-1:0]      alloc_tag,
    input  logic               wb_valid,
    input  logic [TW-1:0]      wb_tag,
    input  logic [DW-1:0]      wb_value,
    input  logic [AUXW-1:0]    wb_aux,
    input  logic               wb_mispred,
    input  logic [NSRC*RW-1:0] src_reg,
    output logic [NSRC-1:0]    src_busy,
    output logic [NSRC-1:0]    src_ready,
    output logic [NSRC*TW-1:0] src_tag,
    output logic [NSRC*DW-1:0] src_value,
    output logic               rf_we,
    output logic [RW-1:0]      rf_waddr,
    output logic [DW-1:0]      rf_wdata,
    output logic               st_valid,
    output logic [AUXW-1:0]    st_addr,
    output logic [DW-1:0]      st_data,
    output logic               flush,
    output logic [AUXW-1:0]    flush_pc
);

    rob_kind_t        kind_in;
    logic             alloc_fire, full, retire_fire;
    logic [TW-1:0]    head, tail;
    logic             head_busy, head_done, head_misp;
    rob_kind_t        head_kind;
    logic [RW-1:0]    head_dest;
    logic [DW-1:0]    head_value;
    logic [AUXW-1:0]  head_aux;
    logic [DEPTH-1:0] done_vec;
    logic [DW-1:0]    val_arr [DEPTH];

    assign kind_in     = rob_kind_t'(alloc_kind);
    assign alloc_ready = rs_free && !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_slots #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .AUXW(AUXW)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .alloc_kind  (kind_in),
        .alloc_dest  (alloc_dest),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .wb_value    (wb_value),
        .wb_aux      (wb_aux),
        .wb_mispred  (wb_mispred),
        .retire_fire (retire_fire),
        .flush       (flush),
        .head        (head),
        .tail        (tail),
        .full        (full),
        .head_busy   (head_busy),
        .head_done   (head_done),
        .head_kind   (head_kind),
        .head_dest   (head_dest),
        .head_value  (head_value),
        .head_aux    (head_aux),
        .head_misp   (head_misp),
        .done_vec    (done_vec),
        .val_arr     (val_arr)
    );

    rob_rename_map #(.NREG(NREG), .NSRC(NSRC), .TW(TW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .set_fire (alloc_fire && (kind_in == KIND_ALU)),
        .set_reg  (alloc_dest),
        .set_tag  (tail),
        .clr_fire (rf_we),
        .clr_reg  (head_dest),
        .clr_tag  (head),
        .src_reg  (src_reg),
        .src_busy (src_busy),
        .src_tag  (src_tag)
    );

    rob_retire #(.RW(RW), .DW(DW), .AUXW(AUXW)) u_retire (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_busy   (head_busy),
        .head_done   (head_done),
        .head_kind   (head_kind),
        .head_dest   (head_dest),
        .head_value  (head_value),
        .head_aux    (head_aux),
        .head_misp   (head_misp),
        .retire_fire (retire_fire),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_data     (st_data),
        .flush       (flush),
        .flush_pc    (flush_pc)
    );

    // Operand forwarding from a finished producer entry.
    for (genvar s = 0; s < NSRC; s++) begin : g_fwd
        logic [TW-1:0] t;
        assign t                      = src_tag[s*TW +: TW];
        assign src_ready[s]           = src_busy[s] && done_vec[t];
        assign src_value[s*DW +: DW]  = src_ready[s] ? val_arr[t] : '0;
    end

    assert_ready_implies_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready[0] |-> src_busy[0]);

endmodule

// File: tb/inorder_rob_test.sv
// Directed sweeps on a 4-entry, 8-register configuration.
module inorder_rob_test;
    localparam int DEPTH = 4, NREG = 8, DW = 16, AUXW = 16, NSRC = 2;
    localparam int TW = 2, RW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, rs_free, alloc_valid, alloc_ready;
    logic [1:0] alloc_kind;
    logic [RW-1:0] alloc_dest;
    logic [TW-1:0] alloc_tag;
    logic wb_valid, wb_mispred;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_value;
    logic [AUXW-1:0] wb_aux;
    logic [NSRC*RW-1:0] src_reg;
    logic [NSRC-1:0] src_busy, src_ready;
    logic [NSRC*TW-1:0] src_tag;
    logic [NSRC*DW-1:0] src_value;
    logic rf_we, st_valid, flush;
    logic [RW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata, st_data;
    logic [AUXW-1:0] st_addr, flush_pc;

    int vectors = 0;
    int fails = 0;
    int exp_tail;

    inorder_rob #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .AUXW(AUXW), .NSRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .rs_free(rs_free), .alloc_valid(alloc_valid),
        .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_ready(alloc_ready),
        .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_aux(wb_aux), .wb_mispred(wb_mispred), .src_reg(src_reg), .src_busy(src_busy),
        .src_ready(src_ready), .src_tag(src_tag), .src_value(src_value), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .flush(flush), .flush_pc(flush_pc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        alloc_valid = 1'b0;
        wb_valid    = 1'b0;
        wb_mispred  = 1'b0;
    endtask

    task automatic alloc(input int k, input int d);
        wb_valid    = 1'b0;
        alloc_valid = 1'b1;
        alloc_kind  = 2'(k);
        alloc_dest  = RW'(d);
    endtask

    task automatic wb(input int t, input int v, input int a, input bit m);
        alloc_valid = 1'b0;
        wb_valid    = 1'b1;
        wb_tag      = TW'(t);
        wb_value    = DW'(v);
        wb_aux      = AUXW'(a);
        wb_mispred  = m;
    endtask

    task automatic look(input int r0, input int r1);
        src_reg = {RW'(r1), RW'(r0)};
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rs_free = 1'b1; idle(); alloc_kind = 0; alloc_dest = 0;
        wb_tag = 0; wb_value = 0; wb_aux = 0; look(1, 2);
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "alloc_tag", alloc_tag, 0);
        chk("R1", "rf_we", rf_we, 0);
        chk("R1", "st_valid", st_valid, 0);
        chk("R1", "flush", flush, 0);
        chk("R1", "src_busy", src_busy, 0);
        step();

        // R2 no station free: request dropped
        rs_free = 1'b0; alloc(0, 1); #1;
        chk("R2", "ready without station", alloc_ready, 0);
        step();
        rs_free = 1'b1; idle(); look(1, 2); #1;
        chk("R2", "tag after refused", alloc_tag, 0);
        chk("R2", "r1 not renamed", src_busy[0], 0);
        step();

        // R2 fill in ascending order
        for (int i = 0; i < DEPTH; i++) begin
            alloc(0, i + 1); #1;
            chk("R2", "ready while filling", alloc_ready, 1);
            chk("R2", "tag order", alloc_tag, i);
            step();
        end
        // R3 full; R9 pending lookups
        alloc(0, 5); look(1, 4); #1;
        chk("R3", "ready when full", alloc_ready, 0);
        chk("R9", "r1 busy", src_busy[0], 1);
        chk("R9", "r1 tag", src_tag[1:0], 0);
        chk("R9", "r1 ready", src_ready[0], 0);
        chk("R9", "r4 tag", src_tag[3:2], 3);
        step();
        wb(3, 16'h3003, 0, 0); look(5, 1); #1;
        chk("R3", "dropped request renamed", src_busy[0], 0);
        chk("R5", "no retire yet", rf_we, 0);
        step();
        wb(1, 16'h1001, 0, 0); #1;
        chk("R5", "younger done, head not", rf_we, 0);
        step();
        idle(); look(2, 1); #1;
        chk("R9", "r2 ready", src_ready[0], 1);
        chk("R9", "r2 value", src_value[15:0], 16'h1001);
        chk("R9", "r1 still waiting", src_ready[1], 0);
        chk("R5", "head still waiting", rf_we, 0);
        step();
        wb(0, 16'h0A0A, 0, 0); step();
        idle(); #1;
        chk("R6", "rf_we e0", rf_we, 1);
        chk("R6", "waddr e0", rf_waddr, 1);
        chk("R6", "wdata e0", rf_wdata, 16'h0A0A);
        step(); #1;
        chk("R6", "waddr e1", rf_waddr, 2);
        chk("R6", "wdata e1", rf_wdata, 16'h1001);
        step();
        wb(2, 16'h2002, 0, 0); #1;
        chk("R5", "stall on unfinished e2", rf_we, 0);
        step();
        idle(); #1;
        chk("R5", "order e2 waddr", rf_waddr, 3);
        chk("R6", "e2 wdata", rf_wdata, 16'h2002);
        step(); #1;
        chk("R5", "order e3 waddr", rf_waddr, 4);
        chk("R6", "e3 wdata", rf_wdata, 16'h3003);
        step();
        look(4, 1); #1;
        chk("R5", "empty no retire", rf_we, 0);
        chk("R10", "r4 cleared", src_busy[0], 0);
        chk("R2", "tag wrapped", alloc_tag, 0);
        chk("R3", "ready after drain", alloc_ready, 1);
        step();

        // R10 two writers of r5
        alloc(0, 5); #1; chk("R2", "tag", alloc_tag, 0); step();
        alloc(0, 5); #1; chk("R2", "tag", alloc_tag, 1); step();
        idle(); look(5, 0); #1;
        chk("R9", "r5 newest tag", src_tag[1:0], 1);
        step();
        wb(0, 16'h5000, 0, 0); step();
        idle(); #1;
        chk("R6", "older r5 write", rf_wdata, 16'h5000);
        step();
        wb(1, 16'h5111, 0, 0); #1;
        chk("R10", "r5 kept busy", src_busy[0], 1);
        chk("R10", "r5 keeps tag", src_tag[1:0], 1);
        step();
        idle(); #1;
        chk("R6", "newer r5 write", rf_wdata, 16'h5111);
        step(); #1;
        chk("R10", "r5 released", src_busy[0], 0);
        step();

        // R7 store
        alloc(1, 0); #1; chk("R2", "store tag", alloc_tag, 2); step();
        wb(2, 16'hBEEF, 16'h0040, 0); step();
        idle(); look(0, 0); #1;
        chk("R7", "st_valid", st_valid, 1);
        chk("R7", "st_addr", st_addr, 16'h0040);
        chk("R7", "st_data", st_data, 16'hBEEF);
        chk("R7", "no rf write", rf_we, 0);
        chk("R7", "no rename", src_busy[0], 0);
        step();

        // R8 correctly predicted branch
        alloc(2, 0); #1; chk("R2", "branch tag", alloc_tag, 3); step();
        wb(3, 0, 16'h0099, 0); step();
        idle(); #1;
        chk("R8", "no flush", flush, 0);
        chk("R8", "no rf", rf_we, 0);
        chk("R8", "no store", st_valid, 0);
        step(); #1;
        chk("R8", "branch retired", alloc_tag, 0);
        step();

        // R8 mispredicted branch with finished younger entry
        alloc(0, 6); step();
        alloc(2, 0); step();
        alloc(0, 7); step();
        wb(2, 16'h7777, 0, 0); step();
        wb(1, 0, 16'h1234, 1); step();
        wb(0, 16'h6666, 0, 0); step();
        idle(); #1;
        chk("R6", "pre-branch write", rf_wdata, 16'h6666);
        step();
        alloc(0, 1); #1;
        chk("R8", "flush", flush, 1);
        chk("R8", "flush_pc", flush_pc, 16'h1234);
        chk("R8", "alloc blocked", alloc_ready, 0);
        chk("R8", "no rf on flush", rf_we, 0);
        step();
        idle(); look(7, 1); #1;
        chk("R8", "younger discarded", rf_we, 0);
        chk("R8", "single flush", flush, 0);
        chk("R8", "status cleared", src_busy, 0);
        chk("R8", "tail reset", alloc_tag, 0);
        step();

        // R4 stray result then real allocation
        wb(0, 16'hDEAD, 0, 0); step();
        alloc(0, 2); #1; chk("R2", "tag", alloc_tag, 0); step();
        idle(); look(2, 0); #1;
        chk("R4", "no retire of stale", rf_we, 0);
        chk("R4", "not ready", src_ready[0], 0);
        step(); #1;
        chk("R4", "still waiting", rf_we, 0);
        wb(0, 16'h2222, 0, 0);
        step();
        idle(); #1;
        chk("R4", "own result", rf_wdata, 16'h2222);
        step();

        // Sweep every kind against both mispredict values
        exp_tail = 1;
        for (int k = 0; k < 3; k++) begin
            for (int m = 0; m < 2; m++) begin
                int v, a;
                v = 16'h0100 * (k + 1) + m;
                a = 16'h0020 + k * 2 + m;
                alloc(k, k + 1); #1;
                chk("R2", "sweep tag", alloc_tag, exp_tail);
                step();
                wb(exp_tail, v, a, m[0]);
                exp_tail = (exp_tail + 1) % DEPTH;
                step();
                idle(); #1;
                chk("R6", "sweep rf_we", rf_we, (k == 0) ? 1 : 0);
                chk("R7", "sweep st_valid", st_valid, (k == 1) ? 1 : 0);
                chk("R8", "sweep flush", flush, (k == 2 && m == 1) ? 1 : 0);
                if (k == 0) chk("R6", "sweep wdata", rf_wdata, v);
                if (k == 1) chk("R7", "sweep addr", st_addr, a);
                if (k == 2 && m == 1) chk("R8", "sweep pc", flush_pc, a);
                step();
                if (k == 2 && m == 1) exp_tail = 0;
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule